// File: doc/BRIEF.md
# Phased Clock Divider with Synchronous Restart

This block divides a fast input clock by an integer picked from a fixed set of sixteen ratios and drives one divided clock. It is meant to sit beside identical copies in a clock fan-out tree. All copies share one active-low restart request. While that request is active, each divider parks its output low. When the request is released, every divider restarts on the same input cycle. Each divider can then hold back its first rising edge by a programmable number of input cycles. This gives coarse output-to-output skew in steps of one input period.

The ratio index and the skew word are sampled only when a restart happens. A ratio or skew change made while the output is running therefore cannot produce a runt pulse. Ratio index 0 selects divide-by-1. In that mode the counter is idle and the input clock is passed straight to the output, whatever the restart line does. A separate power-down control parks the divider and forces the output low. Leaving power-down restarts the divider in the same way a restart release does. Reset deassertion also counts as a restart, so every copy starts aligned.

The restart line is only honoured once it has been sampled low on a programmable number of consecutive input edges. Shorter glitches are ignored.

Sequencer states: `ST_OFF` (powered down), `ST_HOLD` (parked after a qualified request or reset), `ST_RESTART` (fixed four-cycle wait after release), `ST_SKEW` (per-output skew wait), `ST_RUN` (dividing). The transitions are:
- any state to `ST_OFF` when power-down is set;
- `ST_OFF` to `ST_RESTART` when power-down clears;
- `ST_HOLD` to `ST_RESTART` when the restart line is sampled high;
- `ST_RESTART` to `ST_RUN` when the wait ends and the skew is 0;
- `ST_RESTART` to `ST_SKEW` when the wait ends and the skew is non-zero;
- `ST_SKEW` to `ST_RUN` when the skew count expires;
- `ST_RESTART`, `ST_SKEW` or `ST_RUN` to `ST_HOLD` on a qualified request.

Top module: `phased_clkdiv`

## Requirements
- R1: Ratio index i selects divide ratio N from the list 1, 2, 3, 4, 5, 6, 8, 9, 10, 12, 15, 16, 18, 24, 30, 32 (index 0 to 15 in that order). Even ratios give N/2 input cycles high followed by N/2 low.
- R2: For odd ratios the output is high for floor(N/2) input cycles and low for the rest of the period.
- R3: Index 0 (divide-by-1) passes the input clock straight to the output and ignores the restart line. The output is high while clk is high and low while clk is low, even with sync_n held low.
- R4: Once sync_n has been sampled low on sync_min consecutive rising edges (a value of 0 is treated as 1), the divided output goes low on that edge. It stays low while sync_n remains low.
- R5: Counting the first rising edge that samples sync_n high after a qualified request as edge 0, the first rising edge of the output occurs on edge 4 + p, where p is the skew word.
- R6: A skew word equal to N delays the first edge by exactly N input cycles. The output therefore lines up with the skew-0 alignment.
- R7: A low pulse on sync_n that spans fewer than sync_min sampling edges has no effect. The output keeps toggling through it.
- R8: While cfg_off is set, the output is held low, and this includes divide-by-1. The first rising edge sampling cfg_off clear acts as edge 0 of R5.
- R9: Reset drives the output low. The first rising edge after reset release that samples sync_n high acts as edge 0 of R5.
- R10: Changes to cfg_ratio_idx or cfg_phase while the output is running take effect only at the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sync_n | input | 1 | Shared active-low restart request, synchronous to clk |
| cfg_off | input | 1 | Power-down: parks the divider, output low |
| cfg_ratio_idx | input | 4 | Divide-ratio index (R1) |
| cfg_phase | input | 4 | Skew in input cycles applied after restart |
| sync_min | input | SYNC_W | Minimum qualifying low width of sync_n, in edges |
| clk_out | output | 1 | Divided clock |

## Verification
The interesting collision is a new qualified restart request arriving while the divider is still in its restart or skew wait. The request must win on that same edge, and the later release must start a fresh 4 + p count. The bench provokes this by releasing with a skew of 10 and re-asserting sync_n a few cycles into the wait. It then checks that the output stays low throughout and that the first rising edge lands exactly 14 edges after the second release. A second overlap, power-down asserted while divide-by-1 is latched, is judged by sampling the output in both clock phases and requiring it to be low in both.

// File: rtl/phased_clkdiv_pkg.sv
package phased_clkdiv_pkg;

    localparam int IDX_W   = 4;
    localparam int RATIO_W = 6;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_HOLD,
        ST_RESTART,
        ST_SKEW,
        ST_RUN
    } seq_st_t;

    function automatic logic [RATIO_W-1:0] ratio_of(input logic [IDX_W-1:0] idx);
        logic [RATIO_W-1:0] n;
        unique case (idx)
            4'd0:  n = 6'd1;
            4'd1:  n = 6'd2;
            4'd2:  n = 6'd3;
            4'd3:  n = 6'd4;
            4'd4:  n = 6'd5;
            4'd5:  n = 6'd6;
            4'd6:  n = 6'd8;
            4'd7:  n = 6'd9;
            4'd8:  n = 6'd10;
            4'd9:  n = 6'd12;
            4'd10: n = 6'd15;
            4'd11: n = 6'd16;
            4'd12: n = 6'd18;
            4'd13: n = 6'd24;
            4'd14: n = 6'd30;
            default: n = 6'd32;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/phased_clkdiv_syncq.sv
module phased_clkdiv_syncq #(
    parameter int SYNC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_n,
    input  logic [SYNC_W-1:0] sync_min,
    output logic              sync_hit,
    output logic              sync_hi
);

    localparam logic [SYNC_W-1:0] CNT_MAX = '1;

    logic [SYNC_W-1:0] lo_cnt;
    logic [SYNC_W-1:0] min_eff;
    logic [SYNC_W:0]   lo_next;

    assign min_eff = (sync_min == '0) ? SYNC_W'(1) : sync_min;
    assign lo_next = {1'b0, lo_cnt} + (SYNC_W+1)'(1);
    assign sync_hi = sync_n;
    assign sync_hit = !sync_n && (lo_next >= {1'b0, min_eff});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt <= '0;
        end else if (sync_n) begin
            lo_cnt <= '0;
        end else if (lo_cnt != CNT_MAX) begin
            lo_cnt <= lo_cnt + SYNC_W'(1);
        end
    end

endmodule

// File: rtl/phased_clkdiv_seq.sv
module phased_clkdiv_seq
    import phased_clkdiv_pkg::*;
#(
    parameter int PHASE_W     = 4,
    parameter int RESTART_CYC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_off,
    input  logic               sync_hit,
    input  logic               sync_hi,
    input  logic [PHASE_W-1:0] skew,
    output seq_st_t            st,
    output logic               latch_cfg,
    output logic               go_run,
    output logic               run_adv
);

    localparam int CW = (PHASE_W > $clog2(RESTART_CYC)) ? PHASE_W : $clog2(RESTART_CYC);
    localparam logic [CW-1:0] WAIT_LAST = CW'(RESTART_CYC - 1);

    seq_st_t       st_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_HOLD;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        if (cfg_off) begin
            st_nx  = ST_OFF;
            cnt_nx = '0;
        end else begin
            unique case (st)
                ST_OFF: begin
                    st_nx  = ST_RESTART;
                    cnt_nx = '0;
                end
                ST_HOLD: begin
                    if (sync_hi) begin
                        st_nx  = ST_RESTART;
                        cnt_nx = '0;
                    end
                end
                ST_RESTART: begin
                    if (sync_hit) begin
                        st_nx = ST_HOLD;
                    end else if (cnt == WAIT_LAST) begin
                        if (skew == '0) begin
                            st_nx = ST_RUN;
                        end else begin
                            st_nx  = ST_SKEW;
                            cnt_nx = CW'(skew) - CW'(1);
                        end
                    end else begin
                        cnt_nx = cnt + CW'(1);
                    end
                end
                ST_SKEW: begin
                    if (sync_hit) begin
                        st_nx = ST_HOLD;
                    end else if (cnt == '0) begin
                        st_nx = ST_RUN;
                    end else begin
                        cnt_nx = cnt - CW'(1);
                    end
                end
                ST_RUN: begin
                    if (sync_hit) begin
                        st_nx = ST_HOLD;
                    end
                end
                default: st_nx = ST_HOLD;
            endcase
        end
    end

    always_comb begin
        latch_cfg = (st_nx == ST_RESTART) && ((st == ST_HOLD) || (st == ST_OFF));
        go_run    = (st_nx == ST_RUN) && (st != ST_RUN);
        run_adv   = (st_nx == ST_RUN) && (st == ST_RUN);
    end

endmodule

// File: rtl/phased_clkdiv_ctr.sv
module phased_clkdiv_ctr #(
    parameter int RATIO_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               adv,
    input  logic [RATIO_W-1:0] ratio,
    output logic               lvl
);

    logic [RATIO_W-1:0] cnt;
    logic [RATIO_W-1:0] cnt_nx;
    logic [RATIO_W-1:0] high_len;

    assign high_len = ratio >> 1;
    assign cnt_nx   = (cnt == ratio - RATIO_W'(1)) ? '0 : cnt + RATIO_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            lvl <= 1'b0;
        end else if (load) begin
            cnt <= '0;
            lvl <= 1'b1;
        end else if (adv) begin
            cnt <= cnt_nx;
            lvl <= (cnt_nx < high_len);
        end else begin
            cnt <= '0;
            lvl <= 1'b0;
        end
    end

endmodule

// File: rtl/phased_clkdiv.sv
module phased_clkdiv
    import phased_clkdiv_pkg::*;
#(
    parameter int SYNC_W      = 4,
    parameter int RESTART_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_n,
    input  logic              cfg_off,
    input  logic [3:0]        cfg_ratio_idx,
    input  logic [3:0]        cfg_phase,
    input  logic [SYNC_W-1:0] sync_min,
    output logic              clk_out
);

    localparam int PHASE_W = 4;

    seq_st_t            st;
    logic               sync_hit, sync_hi;
    logic               latch_cfg, go_run, run_adv;
    logic [IDX_W-1:0]   lat_idx;
    logic [PHASE_W-1:0] lat_phase;
    logic               lat_bypass;
    logic [RATIO_W-1:0] lat_ratio;
    logic               div_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_idx   <= IDX_W'(1);
            lat_phase <= '0;
        end else if (latch_cfg) begin
            lat_idx   <= cfg_ratio_idx;
            lat_phase <= cfg_phase;
        end
    end

    assign lat_bypass = (lat_idx == '0);
    assign lat_ratio  = ratio_of(lat_idx);

    phased_clkdiv_syncq #(.SYNC_W(SYNC_W)) u_syncq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_n   (sync_n),
        .sync_min (sync_min),
        .sync_hit (sync_hit),
        .sync_hi  (sync_hi)
    );

    phased_clkdiv_seq #(.PHASE_W(PHASE_W), .RESTART_CYC(RESTART_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_off   (cfg_off),
        .sync_hit  (sync_hit),
        .sync_hi   (sync_hi),
        .skew      (lat_phase),
        .st        (st),
        .latch_cfg (latch_cfg),
        .go_run    (go_run),
        .run_adv   (run_adv)
    );

    phased_clkdiv_ctr #(.RATIO_W(RATIO_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (go_run && !lat_bypass),
        .adv   (run_adv && !lat_bypass),
        .ratio (lat_ratio),
        .lvl   (div_lvl)
    );

    assign clk_out = (lat_bypass && (st != ST_OFF)) ? clk : div_lvl;

endmodule

// File: rtl/phased_clkdiv_chk.sv
module phased_clkdiv_chk
    import phased_clkdiv_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_off,
    input logic       sync_hit,
    input logic       div_lvl,
    input logic       lat_bypass,
    input seq_st_t    st,
    input logic [3:0] lat_idx
);

    // R8
    off_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_off |=> !div_lvl);

    // R4
    freeze_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_hit && !cfg_off) |=> !div_lvl);

    // R5
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_RESTART) || (st == ST_SKEW)) |-> !div_lvl);

    // R10
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_RUN) && ($past(st) == ST_RUN)) |-> $stable(lat_idx));

    // R3
    bypass_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lat_bypass |-> !div_lvl);

endmodule

bind phased_clkdiv phased_clkdiv_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_off    (cfg_off),
    .sync_hit   (sync_hit),
    .div_lvl    (div_lvl),
    .lat_bypass (lat_bypass),
    .st         (st),
    .lat_idx    (lat_idx)
);

// File: tb/sim_phased_clkdiv.sv
module sim_phased_clkdiv;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;
    // {ratio index, skew, expected N, expected high cycles}
    localparam int VEC [NVEC][4] = '{
        '{1, 0, 2, 1},  '{2, 0, 3, 1},   '{4, 1, 5, 2},  '{7, 3, 9, 4},
        '{10, 0, 15, 7}, '{15, 5, 32, 16}, '{3, 4, 4, 2}, '{5, 2, 6, 3},
        '{6, 0, 8, 4},  '{8, 1, 10, 5},  '{9, 0, 12, 6}, '{11, 15, 16, 8},
        '{12, 2, 18, 9}, '{13, 0, 24, 12}, '{14, 7, 30, 15}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_n = 1'b1;
    logic       cfg_off = 1'b0;
    logic [3:0] cfg_ratio_idx = 4'd3;
    logic [3:0] cfg_phase = 4'd2;
    logic [3:0] smin = 4'd2;
    logic       clk_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phased_clkdiv u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .sync_n        (sync_n),
        .cfg_off       (cfg_off),
        .cfg_ratio_idx (cfg_ratio_idx),
        .cfg_phase     (cfg_phase),
        .sync_min      (smin),
        .clk_out       (clk_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic smp(output logic v);
        @(posedge clk);
        #(CLK_PERIOD/4);
        v = clk_out;
    endtask

    task automatic smp_neg(output logic v);
        @(negedge clk);
        #(CLK_PERIOD/4);
        v = clk_out;
    endtask

    // assert sync_n long enough to qualify, then confirm the output is parked
    task automatic do_sync(input bit check_low);
        logic v;
        @(negedge clk) sync_n = 1'b0;
        repeat (int'(smin)) @(posedge clk);
        smp(v);
        if (check_low) chk(v === 1'b0, "R4", int'(v), 0);
    endtask

    // call right after the release edge has been set up at a negedge
    task automatic measure(input int p, input int n, input int h,
                           input string tr, input string td);
        logic v;
        int kr;
        int hi;
        int lo;
        kr = -1;
        for (int k = 0; k < 40 && kr < 0; k++) begin
            smp(v);
            if (v === 1'b1) kr = k;
        end
        chk(kr == 4 + p, tr, kr, 4 + p);
        hi = 1;
        smp(v);
        while (v === 1'b1 && hi < 40) begin
            hi++;
            smp(v);
        end
        lo = 1;
        smp(v);
        while (v !== 1'b1 && lo < 40) begin
            lo++;
            smp(v);
        end
        chk(hi == h, td, hi, h);
        chk(hi + lo == n, td, hi + lo, n);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic v;
        logic prev;
        int tog;

        // R9: reset state and reset release acting as a restart
        #(CLK_PERIOD * 3 + 1);
        chk(clk_out === 1'b0, "R9", int'(clk_out), 0);
        @(negedge clk) rst_n = 1'b1;
        measure(2, 4, 2, "R9", "R1");

        // vector table: every ratio, several skews
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            cfg_ratio_idx = 4'(VEC[i][0]);
            cfg_phase     = 4'(VEC[i][1]);
            do_sync(1'b1);
            @(negedge clk) sync_n = 1'b1;
            measure(VEC[i][1], VEC[i][2], VEC[i][3], "R5",
                    (VEC[i][2] % 2 == 1) ? "R2" : "R1");
        end

        // R6: skew equal to the ratio shifts by one full period
        @(negedge clk);
        cfg_ratio_idx = 4'd3;
        cfg_phase     = 4'd4;
        do_sync(1'b0);
        @(negedge clk) sync_n = 1'b1;
        measure(4, 4, 2, "R6", "R6");

        // R7: short glitch (3 low edges with minimum 4) ignored on /2
        @(negedge clk);
        cfg_ratio_idx = 4'd1;
        cfg_phase     = 4'd0;
        do_sync(1'b0);
        @(negedge clk) sync_n = 1'b1;
        measure(0, 2, 1, "R5", "R1");
        smin = 4'd4;
        smp(prev);
        tog = 0;
        @(negedge clk) sync_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            smp(v);
            if (v !== prev) tog++;
            prev = v;
        end
        @(negedge clk) sync_n = 1'b1;
        for (int k = 0; k < 2; k++) begin
            smp(v);
            if (v !== prev) tog++;
            prev = v;
        end
        chk(tog == 5, "R7", tog, 5);
        smin = 4'd2;

        // R10: ratio change while running has no effect until restart
        @(negedge clk) cfg_ratio_idx = 4'd6;
        smp(prev);
        tog = 0;
        for (int k = 0; k < 7; k++) begin
            smp(v);
            if (v !== prev) tog++;
            prev = v;
        end
        chk(tog == 7, "R10", tog, 7);
        do_sync(1'b1);
        @(negedge clk) sync_n = 1'b1;
        measure(0, 8, 4, "R10", "R10");

        // overlap: new request during the skew wait restarts the count
        @(negedge clk);
        cfg_ratio_idx = 4'd3;
        cfg_phase     = 4'd10;
        do_sync(1'b0);
        @(negedge clk) sync_n = 1'b1;
        tog = 0;
        for (int k = 0; k < 6; k++) begin
            smp(v);
            if (v !== 1'b0) tog++;
        end
        do_sync(1'b1);
        chk(tog == 0, "R5", tog, 0);
        @(negedge clk) sync_n = 1'b1;
        measure(10, 4, 2, "R5", "R1");

        // R3: divide-by-1 follows clk and ignores a held sync request
        @(negedge clk);
        cfg_ratio_idx = 4'd0;
        cfg_phase     = 4'd0;
        do_sync(1'b0);
        @(negedge clk) sync_n = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk) sync_n = 1'b0;
        for (int k = 0; k < 4; k++) begin
            smp(v);
            chk(v === 1'b1, "R3", int'(v), 1);
            smp_neg(v);
            chk(v === 1'b0, "R3", int'(v), 0);
        end
        @(negedge clk) sync_n = 1'b1;
        repeat (2) @(posedge clk);

        // R8: power-down overrides bypass, release restarts with new config
        @(negedge clk) cfg_off = 1'b1;
        @(posedge clk);
        tog = 0;
        for (int k = 0; k < 4; k++) begin
            smp(v);
            if (v !== 1'b0) tog++;
            smp_neg(v);
            if (v !== 1'b0) tog++;
        end
        chk(tog == 0, "R8", tog, 0);
        @(negedge clk);
        cfg_ratio_idx = 4'd3;
        cfg_phase     = 4'd1;
        cfg_off       = 1'b0;
        measure(1, 4, 2, "R8", "R8");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule